// File: doc/BRIEF.md
# Half-Full Interrupting Sample Buffer

This block is a deep first-in first-out store for 16-bit tagged converter samples. It sits between a producer that pushes one word per cycle and a host that sees only a narrow byte-wide register bus. Samples are accepted only while the host has switched the buffer on. When the fill level first reaches half of the depth, the block raises an interrupt line. The host then drains half the depth in one block, and the interrupt stays raised until the host clears it.

The host reads each word as two bytes. It reads the low byte first and then the high byte, and reading the high byte removes the word from the buffer. A single status byte reports three things: whether the buffer is empty, whether it has reached the half-full threshold, and a sticky flag recording that a sample was lost because the buffer was full. One write to the flush register puts the buffer back to a clean empty state.

Top module: `sfifo_hf_irq`

## Requirements
- R1: After reset the buffer is disabled and empty, the status byte reads 0x01 and `irq` is low.
- R2: A bus write to address 6 sets the enable from data bit 0 (1 enables, 0 disables). Pushes arriving while the buffer is disabled are dropped and do not change the level.
- R3: Words leave in the order they were pushed. A read of address 23 returns bits 7:0 of the oldest word without removing it. A read of address 24 returns bits 15:8 of that word and removes it.
- R4: A read of address 25 returns the status byte: bit 0 is empty, bit 1 is level at or above half the depth, bit 2 is the overflow flag, and bits 7:3 read zero.
- R5: A push that arrives while the buffer is full, with no removal in the same cycle, is dropped and sets the overflow flag. The flag stays set until a flush, and the stored contents are unchanged.
- R6: While the buffer is enabled, `irq` goes high one cycle after the level first reaches half the depth. It stays high while the level keeps rising.
- R7: A bus write of any value to address 20 clears `irq` and leaves the stored data and the level unchanged.
- R8: A bus write to address 25 empties the buffer and, in that one cycle, clears the overflow flag, the half-full flag and `irq`.
- R9: A read of address 24 while the buffer is empty removes nothing: the level stays 0 and the next pushed word is the first word read out.
- R10: When the buffer is full, a push and a removal in the same cycle are both performed. The level stays at the full depth and no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Producer offers a sample this cycle |
| push_data | input | DATA_W | Sample word from the producer |
| bus_addr | input | ADDR_W | Host register address |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte, valid in the cycle of `bus_rd` |
| irq | output | 1 | Half-full interrupt request |

## Verification
The bench builds the block with a depth of 16 instead of 1024. With that depth the half-full threshold is reached after 8 pushes and the full condition after 16, so the bench can reach the interrupt edge, overflow, the stickiness of the overflow flag and the push-plus-removal case at full level within a few hundred cycles. The data width stays at 16, so the byte split on the host side is exercised at its real width.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
   localparam int BUS_W      = 8;
   localparam int ST_EMPTY   = 0;
   localparam int ST_HALF    = 1;
   localparam int ST_OVF     = 2;
endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 1024,
   localparam int PW    = $clog2(DEPTH),
   localparam int LW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              flush,
   output logic [DATA_W-1:0] head,
   output logic [LW-1:0]     level
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_inc, rp_inc;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
         assign wp_inc = wp + PW'(1);
         assign rp_inc = rp + PW'(1);
      end else begin : g_wrap_cmp
         assign wp_inc = (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
         assign rp_inc = (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en && !flush) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (wr_en) wp <= wp_inc;
         if (rd_en) rp <= rp_inc;
         case ({wr_en, rd_en})
            2'b10:   level <= level + LW'(1);
            2'b01:   level <= level - LW'(1);
            default: level <= level;
         endcase
      end
   end

   assign head = mem[rp];
endmodule

// File: rtl/sfifo_hostif.sv
module sfifo_hostif #(
   parameter int DATA_W  = 16,
   parameter int DEPTH   = 1024,
   parameter int ADDR_W  = 5,
   parameter int A_EN    = 6,
   parameter int A_CLR   = 20,
   parameter int A_LO    = 23,
   parameter int A_HI    = 24,
   parameter int A_CTL   = 25,
   localparam int LW     = $clog2(DEPTH + 1),
   localparam int HALF   = DEPTH / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_valid,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   input  logic [DATA_W-1:0] head,
   input  logic [LW-1:0]     level,
   output logic              push_ok,
   output logic              pop,
   output logic              flush,
   output logic [7:0]        bus_rdata,
   output logic              irq,
   output logic              en,
   output logic              ovf
);
   import sfifo_pkg::*;

   logic full, empty, half, half_q, drop, clr_wr, en_wr;
   logic [7:0] hi_byte;

   assign full   = (level == LW'(DEPTH));
   assign empty  = (level == '0);
   assign half   = (level >= LW'(HALF));
   assign flush  = bus_wr && (bus_addr == ADDR_W'(A_CTL));
   assign clr_wr = bus_wr && (bus_addr == ADDR_W'(A_CLR));
   assign en_wr  = bus_wr && (bus_addr == ADDR_W'(A_EN));
   assign pop    = bus_rd && (bus_addr == ADDR_W'(A_HI)) && !empty && !flush;
   assign push_ok = push_valid && en && (!full || pop) && !flush;
   assign drop    = push_valid && en && full && !pop && !flush;

   generate
      if (DATA_W == 16) begin : g_hi_full
         assign hi_byte = head[15:8];
      end else begin : g_hi_part
         assign hi_byte = {{(16 - DATA_W){1'b0}}, head[DATA_W-1:8]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en     <= 1'b0;
         ovf    <= 1'b0;
         irq    <= 1'b0;
         half_q <= 1'b0;
      end else begin
         if (en_wr) en <= bus_wdata[0];
         if (flush) begin
            ovf    <= 1'b0;
            irq    <= 1'b0;
            half_q <= 1'b0;
         end else begin
            half_q <= half;
            if (drop) ovf <= 1'b1;
            if (clr_wr)                    irq <= 1'b0;
            else if (half && !half_q && en) irq <= 1'b1;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         case (bus_addr)
            ADDR_W'(A_LO):  bus_rdata = head[7:0];
            ADDR_W'(A_HI):  bus_rdata = hi_byte;
            ADDR_W'(A_CTL): begin
               bus_rdata[ST_EMPTY] = empty;
               bus_rdata[ST_HALF]  = half;
               bus_rdata[ST_OVF]   = ovf;
            end
            default: bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/sfifo_hf_irq.sv
module sfifo_hf_irq #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 1024,
   parameter int ADDR_W = 5,
   parameter int A_EN   = 6,
   parameter int A_CLR  = 20,
   parameter int A_LO   = 23,
   parameter int A_HI   = 24,
   parameter int A_CTL  = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_valid,
   input  logic [DATA_W-1:0] push_data,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              irq
);
   localparam int LW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH % 2) != 0) begin : g_bad_depth
         $error("sfifo_hf_irq: DEPTH must be even and at least 2");
      end
      if (DATA_W <= 8 || DATA_W > 16) begin : g_bad_width
         $error("sfifo_hf_irq: DATA_W must be 9..16");
      end
      if ((1 << ADDR_W) <= A_CTL) begin : g_bad_addr
         $error("sfifo_hf_irq: ADDR_W too narrow for register map");
      end
   endgenerate

   logic [DATA_W-1:0] head;
   logic [LW-1:0]     level;
   logic push_ok, pop, flush, en, ovf;

   sfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
      .clk(clk), .rst_n(rst_n), .wr_en(push_ok), .wr_data(push_data),
      .rd_en(pop), .flush(flush), .head(head), .level(level)
   );

   sfifo_hostif #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .A_EN(A_EN),
      .A_CLR(A_CLR), .A_LO(A_LO), .A_HI(A_HI), .A_CTL(A_CTL)
   ) host_i (
      .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .head(head),
      .level(level), .push_ok(push_ok), .pop(pop), .flush(flush),
      .bus_rdata(bus_rdata), .irq(irq), .en(en), .ovf(ovf)
   );
endmodule

// File: rtl/sfifo_hf_irq_chk.sv
module sfifo_hf_irq_chk #(
   parameter int DEPTH  = 1024,
   parameter int ADDR_W = 5,
   parameter int A_CLR  = 20,
   parameter int A_HI   = 24,
   parameter int A_CTL  = 25,
   localparam int LW    = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              push_valid,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic              irq,
   input logic              en,
   input logic              ovf,
   input logic [LW-1:0]     level
);
   logic flush_w, clr_w, pop_w;
   assign flush_w = bus_wr && (bus_addr == ADDR_W'(A_CTL));
   assign clr_w   = bus_wr && (bus_addr == ADDR_W'(A_CLR));
   assign pop_w   = bus_rd && (bus_addr == ADDR_W'(A_HI)) && (level != '0);

   // R8
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_w |=> (level == '0) && !ovf && !irq);
   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));
   // R5
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf && !flush_w |=> ovf);
   // R6
   irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(en));
   // R7
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_w |=> !irq);
   // R2
   disabled_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en && push_valid && !pop_w && !flush_w |=> $stable(level));
endmodule

bind sfifo_hf_irq sfifo_hf_irq_chk #(
   .DEPTH(DEPTH), .ADDR_W(ADDR_W), .A_CLR(A_CLR), .A_HI(A_HI), .A_CTL(A_CTL)
) chk_i (
   .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .bus_addr(bus_addr),
   .bus_wr(bus_wr), .bus_rd(bus_rd), .irq(irq), .en(en), .ovf(ovf),
   .level(level)
);

// File: tb/sfifo_hf_irq_tb_top.sv
module sfifo_hf_irq_tb_top;
   localparam int DEPTH = 16;
   localparam int DW    = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic push_valid = 1'b0;
   logic [DW-1:0] push_data = '0;
   logic [4:0] bus_addr = '0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic irq;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sfifo_hf_irq #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FIAL-free %s", req) ;
      end
   endtask

   task automatic expect_eq(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_addr = 5'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output int v);
      @(negedge clk);
      bus_addr = 5'(a); bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic push(input int d);
      @(negedge clk);
      push_data = DW'(d); push_valid = 1'b1;
      @(negedge clk);
      push_valid = 1'b0;
   endtask

   task automatic pop_word(output int w);
      int lo, hi;
      rd(23, lo);
      rd(24, hi);
      w = (hi << 8) | lo;
   endtask

   task automatic t_reset;
      int s;
      rd(25, s);
      expect_eq("R1 status after reset", s, 8'h01);
      expect_eq("R1 irq after reset", int'(irq), 0);
      push(16'h1111);
      rd(25, s);
      expect_eq("R2 push while disabled ignored", s, 8'h01);
   endtask

   task automatic t_order;
      int w, s, lo;
      wr(6, 1);
      push(16'hA1B2); push(16'h0C3D); push(16'hFFEE);
      rd(23, lo);
      rd(23, w);
      expect_eq("R3 low byte read does not pop", w, lo);
      pop_word(w); expect_eq("R3 first word", w, 16'hA1B2);
      pop_word(w); expect_eq("R3 second word", w, 16'h0C3D);
      pop_word(w); expect_eq("R3 third word", w, 16'hFFEE);
      rd(25, s); expect_eq("R4 empty after drain", s, 8'h01);
   endtask

   task automatic t_underflow;
      int s, w;
      rd(24, s);
      push(16'h5A5A);
      rd(25, s); expect_eq("R9 status after empty pop then push", s, 8'h00);
      pop_word(w); expect_eq("R9 no phantom pop", w, 16'h5A5A);
   endtask

   task automatic t_half_irq;
      int s, w;
      for (int i = 0; i < DEPTH/2 - 1; i++) push(16'h100 + i);
      idle(2);
      expect_eq("R6 irq low below half", int'(irq), 0);
      rd(25, s); expect_eq("R4 below half status", s, 8'h00);
      push(16'h100 + DEPTH/2 - 1);
      expect_eq("R6 irq one cycle late", int'(irq), 0);
      idle(1);
      expect_eq("R6 irq on half edge", int'(irq), 1);
      rd(25, s); expect_eq("R4 half status", s, 8'h02);
      push(16'h200);
      idle(1);
      expect_eq("R6 irq stays high", int'(irq), 1);
      wr(20, 8'h00);
      expect_eq("R7 irq cleared", int'(irq), 0);
      rd(25, s); expect_eq("R7 status unchanged by clear", s, 8'h02);
      pop_word(w); expect_eq("R7 data unchanged by clear", w, 16'h100);
   endtask

   task automatic t_overflow;
      int s, w;
      wr(25, 0);
      rd(25, s); expect_eq("R8 flush empties", s, 8'h01);
      expect_eq("R8 flush clears irq", int'(irq), 0);
      for (int i = 0; i < DEPTH; i++) push(16'h300 + i);
      rd(25, s); expect_eq("R5 full no overflow yet", s, 8'h02);
      push(16'hDEAD);
      rd(25, s); expect_eq("R5 overflow set", s, 8'h06);
      // R10: push and pop in the same cycle at full level
      @(negedge clk);
      bus_addr = 5'd23; bus_rd = 1'b1;
      @(negedge clk);
      bus_addr = 5'd24; push_data = 16'hBEEF; push_valid = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0; push_valid = 1'b0;
      pop_word(w); expect_eq("R5 dropped word absent", w, 16'h301);
      pop_word(w); expect_eq("R5 ovf sticky after pops", w, 16'h302);
      rd(25, s); expect_eq("R5 overflow still set", s, 8'h06);
      for (int i = 3; i < DEPTH; i++) pop_word(w);
      pop_word(w); expect_eq("R10 simultaneous push kept", w, 16'hBEEF);
      rd(25, s); expect_eq("R5 sticky when empty", s, 8'h05);
      wr(25, 0);
      rd(25, s); expect_eq("R8 flush clears overflow", s, 8'h01);
   endtask

   task automatic t_disable;
      int s;
      wr(6, 0);
      for (int i = 0; i < DEPTH; i++) push(i);
      idle(2);
      rd(25, s); expect_eq("R2 disabled pushes dropped", s, 8'h01);
      expect_eq("R2 no irq while disabled", int'(irq), 0);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_order();
      t_underflow();
      t_half_irq();
      t_overflow();
      t_disable();
      done = 1'b1;
   end

   initial begin
      for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule